// File: doc/BRIEF.md
# Stacked-Carrier Multilevel PWM Modulator

This block produces the switching commands for a single leg of a multilevel inverter with LEVELS output levels. A sinusoidal reference is built inside the block from a phase accumulator and a quarter-wave sine table. That reference is scaled by a modulation index, then compared against LEVELS-1 triangular carriers. The carriers all have the same frequency and height. They sit in adjacent bands that together cover the full bus span, from the most negative level up to the most positive. The block outputs one comparator bit per carrier and the output level index, which is the count of comparator bits that are high.

The carriers come from one shared up/down count. Each carrier adds its own band offset to that count and may be phase-inverted. A run-time mode chooses one of three phase layouts: all carriers in phase, carriers above the midpoint opposed to those below it, or each carrier opposed to its neighbours. A new mode is accepted only at the point where the shared count returns to its valley.

For a three-phase system, three copies of the block are placed on the same clock and reset. Their phase offset inputs are set a third of a turn apart.

Top module: `mlcd_pwm`

## Requirements
- R1: While rst_n is low, gate and level are all zero. After reset the phase accumulator is 0, the shared count t is 0 and rising, and the latched mode is in-phase (0).
- R2: The shared count t follows 0,1,...,H,H-1,...,1,0,1,... and has a period of 2H clocks (H = CAR_HALF). Carrier k, for k = 0..NC-1 with NC = LEVELS-1, has the value k*H + t when not inverted and k*H + H - t when inverted. The bands therefore tile the range 0..NC*H without gaps.
- R3: gate[k] is 1 exactly when the unsigned reference u is strictly greater than carrier k. gate and level are registered, so they reflect the state and inputs in place before the preceding rising edge.
- R4: level equals the number of high gate bits. gate is always a thermometer code, meaning its ones are contiguous from bit 0.
- R5: Mode 0 inverts no carrier.
- R6: Mode 1 inverts every carrier k with 2k >= NC, which are the bands at or above the midpoint. Mode 3 behaves as mode 0.
- R7: Mode 2 inverts every odd-numbered carrier.
- R8: The mode input is sampled only on the clock edge where t goes from 1 to 0. A change made at any other time has no effect until the next valley.
- R9: Each clock, the accumulator adds phase_step modulo 2^16. The table index is the top 6 bits of (accumulator + phase_offset), and the sine sample is round(127*sin(2*pi*index/64)), rounded away from zero.
- R10: The signed reference is floor(sample * mod_idx * HS / 2^14), where HS = NC*H/2 and mod_idx is unsigned with 7 fraction bits (128 = 1.0). The unsigned reference is u = reference + HS.
- R11: For overmodulation, the signed reference saturates to the range -HS..+HS before the offset is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Carrier layout: 0 in phase, 1 opposed about midpoint, 2 alternately opposed, 3 as 0 |
| mod_idx | input | 8 | Modulation index, 7 fraction bits |
| phase_step | input | 16 | Reference phase increment per clock |
| phase_offset | input | 16 | Phase added before the table lookup (phase shift between legs) |
| gate | output | LEVELS-1 | One comparator bit per carrier, bit 0 the lowest band |
| level | output | clog2(LEVELS) | Output level index, 0..LEVELS-1 |

## Verification
The assertions make no assumption about the inputs. mode, mod_idx and both phase inputs may change on any cycle, and the thermometer property holds for any modulation index because the reference is clamped to the carrier span. The turning-point properties assume CAR_HALF is at least 2. The stimulus changes inputs only in the low half of the clock. It changes mode in the middle of a carrier period on purpose, so that the deferral to the valley is exercised. It also covers zero, unity and near-maximum modulation indices, as well as several phase offsets.

// File: rtl/mlcd_pwm.sv
module mlcd_pwm #(
  parameter int LEVELS   = 5,
  parameter int CAR_HALF = 16,
  parameter int MI_FRAC  = 7,
  localparam int NC = LEVELS - 1,
  localparam int LW = $clog2(LEVELS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [7:0]    mod_idx,
  input  logic [15:0]   phase_step,
  input  logic [15:0]   phase_offset,
  output logic [NC-1:0] gate,
  output logic [LW-1:0] level
);
  localparam int TW = $clog2(CAR_HALF + 1);
  localparam int HS = NC * CAR_HALF / 2;
  localparam int SH = 7 + MI_FRAC;
  localparam logic [1:0] MODE_POD  = 2'd1;
  localparam logic [1:0] MODE_APOD = 2'd2;

  logic [15:0]   acc_q;
  logic [TW-1:0] tri_q;
  logic          up_q;
  logic [1:0]    mode_q;
  logic [NC-1:0] gd;

  function automatic logic [6:0] qtab(input logic [4:0] i);
    case (i)
      5'd0:  qtab = 7'd0;   5'd1:  qtab = 7'd12;  5'd2:  qtab = 7'd25;
      5'd3:  qtab = 7'd37;  5'd4:  qtab = 7'd49;  5'd5:  qtab = 7'd60;
      5'd6:  qtab = 7'd71;  5'd7:  qtab = 7'd81;  5'd8:  qtab = 7'd90;
      5'd9:  qtab = 7'd98;  5'd10: qtab = 7'd106; 5'd11: qtab = 7'd112;
      5'd12: qtab = 7'd117; 5'd13: qtab = 7'd122; 5'd14: qtab = 7'd125;
      5'd15: qtab = 7'd126; default: qtab = 7'd127;
    endcase
  endfunction

  logic [15:0] ph;
  logic [5:0]  idx;
  logic [4:0]  qi;
  logic [6:0]  mag;
  int          s_i, ref_i, ref_u;

  assign ph  = acc_q + phase_offset;
  assign idx = ph[15:10];
  assign qi  = idx[4] ? 5'd16 - {1'b0, idx[3:0]} : {1'b0, idx[3:0]};
  assign mag = qtab(qi);

  always_comb begin
    s_i   = idx[5] ? -int'(mag) : int'(mag);
    ref_i = (s_i * int'(mod_idx) * HS) >>> SH;
    if (ref_i > HS) ref_i = HS;
    if (ref_i < -HS) ref_i = -HS;
    ref_u = ref_i + HS;
  end

  for (genvar k = 0; k < NC; k++) begin : g_car
    logic inv;
    int   cval;
    always_comb begin
      case (mode_q)
        MODE_POD:  inv = (2 * k >= NC);
        MODE_APOD: inv = (k % 2) == 1;
        default:   inv = 1'b0;
      endcase
      cval = k * CAR_HALF + (inv ? CAR_HALF - int'(tri_q) : int'(tri_q));
    end
    assign gd[k] = ref_u > cval;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tri_q  <= '0;
      up_q   <= 1'b1;
      mode_q <= 2'd0;
      gate   <= '0;
      level  <= '0;
    end else begin
      acc_q <= acc_q + phase_step;
      gate  <= gd;
      level <= LW'($countones(gd));
      if (up_q) begin
        tri_q <= tri_q + 1'b1;
        if (tri_q == TW'(CAR_HALF - 1)) up_q <= 1'b0;
      end else begin
        tri_q <= tri_q - 1'b1;
        if (tri_q == TW'(1)) begin
          up_q   <= 1'b1;
          mode_q <= mode;
        end
      end
    end
  end

  p_thermo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate & (gate + NC'(1))) == '0);
  p_mode_valley_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> tri_q == '0);
  p_peak_turn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tri_q == TW'(CAR_HALF) |=> tri_q == TW'(CAR_HALF - 1));
  p_valley_turn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tri_q == '0 |=> tri_q == TW'(1));
endmodule

// File: tb/mlcd_pwm_test.sv
module mlcd_pwm_test;
  localparam int LEVELS = 5;
  localparam int H  = 16;
  localparam int NC = LEVELS - 1;
  localparam int HS = NC * H / 2;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 0;
  logic [7:0] mod_idx = 0;
  logic [15:0] phase_step = 0, phase_offset = 0;
  logic [NC-1:0] gate;
  logic [2:0] level;
  int total = 0, bad = 0;

  int m_acc, m_tri, m_up, m_mode;

  mlcd_pwm #(.LEVELS(LEVELS), .CAR_HALF(H)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .mod_idx(mod_idx),
    .phase_step(phase_step), .phase_offset(phase_offset),
    .gate(gate), .level(level));

  always #10 clk = ~clk;

  function automatic logic [NC-1:0] expect_g(int acc, int t, int md, int mi, int ofs);
    int ix, s, r, c;
    real v;
    bit inv;
    logic [NC-1:0] g;
    ix = ((acc + ofs) & 16'hFFFF) >> 10;
    v = 127.0 * $sin(2.0 * 3.14159265358979 * ix / 64.0);
    s = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    r = (s * mi * HS) >>> 14;
    if (r > HS) r = HS;
    if (r < -HS) r = -HS;
    for (int k = 0; k < NC; k++) begin
      inv = (md == 1) ? (2 * k >= NC) : (md == 2) ? (k % 2 == 1) : 1'b0;
      c = k * H + (inv ? H - t : t);
      g[k] = (r + HS) > c;
    end
    return g;
  endfunction

  task automatic step_check(input string req);
    logic [NC-1:0] eg;
    eg = expect_g(m_acc, m_tri, m_mode, int'(mod_idx), int'(phase_offset));
    @(posedge clk);
    m_acc = (m_acc + int'(phase_step)) & 16'hFFFF;
    if (m_up != 0) begin
      if (m_tri == H - 1) m_up = 0;
      m_tri++;
    end else begin
      if (m_tri == 1) begin m_up = 1; m_mode = int'(mode); end
      m_tri--;
    end
    @(negedge clk);
    total++;
    if (gate !== eg || int'(level) != $countones(eg)) begin
      bad++;
      $display("FAIL %s: gate=%b level=%0d expected gate=%b level=%0d",
               req, gate, level, eg, $countones(eg));
    end
  endtask

  task automatic run(input string req, input int n);
    for (int i = 0; i < n; i++) step_check(req);
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    total++;
    if (gate !== '0 || level !== '0) begin
      bad++;
      $display("FAIL R1: gate=%b level=%0d expected gate=0 level=0", gate, level);
    end
    m_acc = 0; m_tri = 0; m_up = 1; m_mode = 0;
    mode = 2'd2;
    rst_n = 1;
    run("R1", 40);
  endtask

  task automatic t_zero_index;
    mod_idx = 0; phase_step = 16'd1024;
    run("R2", 96);
    mod_idx = 8'd64;
    run("R10", 128);
  endtask

  task automatic t_in_phase;
    mode = 0; mod_idx = 8'd128; phase_step = 16'd97;
    run("R5", 700);
    phase_step = 16'd1024;
    run("R3", 128);
  endtask

  task automatic t_opposed;
    mode = 2'd1;
    run("R8", 70);
    run("R6", 200);
    mode = 2'd3;
    run("R6", 100);
  endtask

  task automatic t_alternate;
    mode = 2'd2;
    run("R8", 70);
    run("R7", 300);
  endtask

  task automatic t_overmod;
    mod_idx = 8'd255; phase_step = 16'd1024;
    run("R11", 160);
    mod_idx = 8'd166;
    run("R11", 160);
  endtask

  task automatic t_phase;
    mod_idx = 8'd128;
    phase_offset = 16'd21845;
    run("R9", 150);
    phase_offset = 16'd43690; phase_step = 16'd300;
    run("R9", 150);
    phase_offset = 0;
  endtask

  task automatic t_thermo;
    mode = 2'd1; mod_idx = 8'd200; phase_step = 16'd700;
    for (int i = 0; i < 200; i++) begin
      step_check("R4");
      total++;
      if ((gate & (gate + 1'b1)) != '0) begin
        bad++;
        $display("FAIL R4: gate=%b expected thermometer code", gate);
      end
    end
  endtask

  initial begin
    #(100000 * 20);
    bad++;
    $display("FAIL watchdog: run not complete, expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_zero_index();
    t_in_phase();
    t_opposed();
    t_alternate();
    t_overmod();
    t_phase();
    t_thermo();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule